// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a 256-byte serial EEPROM on a two-wire bus. The system clock samples the clock line and the data line, and the block finds START, STOP and both clock edges by comparing each sample with the one before it. The data output is open-drain in intent: a 1 releases the line and a 0 pulls it low. The surrounding logic combines this output with the other drivers on the wire.

A transfer opens with START and a device byte. The upper four bits of that byte must match a fixed pattern. Bit 0 chooses the direction. A write continues with a word address that sets the internal pointer, then any number of data bytes, each stored at the pointer. A read returns bytes from the current pointer for as long as the master acknowledges. Every shift is MSB first. The array clears on reset, and nothing persists across resets.

The block acts on an SCL edge or a START/STOP two system clocks after the line changes. One clock registers the new sample and one registers the response.

Top module: `eepromSlave`

## Requirements
- R1: After reset the data output is released (1), the address pointer is 0 and all 256 bytes read as 0x00.
- R2: START (SDA falls while SCL stays high) begins a new device byte from any state. STOP (SDA rises while SCL stays high) returns the block to idle. A data byte cut off by STOP is not stored.
- R3: The device byte is shifted in MSB first on SCL rising edges. It is accepted only when its bits 7:4 equal 4'b1010, and bits 3:1 are don't-care. Any other value is not acknowledged, and until the next START every byte is ignored: nothing is stored and the pointer does not move.
- R4: For each byte it accepts, the slave drives the output low from the rising edge of the ninth SCL pulse until that pulse's falling edge, then releases it.
- R5: With device bit 0 at 0, the next byte is taken as the word address and loaded into the pointer.
- R6: Each later data byte of a write is stored at the pointer and acknowledged, and the pointer then increments modulo 256 (0xFF wraps to 0x00). Any number of bytes may follow.
- R7: With device bit 0 at 1, the slave sends the byte at the current pointer MSB first. Each bit appears on an SCL rising edge. The output is released during the master's acknowledge pulse, and the pointer increments modulo 256 after each byte.
- R8: A master acknowledge (SDA low on the ninth rising edge) makes the slave send the next byte. A master NACK (SDA high) returns it to idle, and the output stays released until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Sampled level of the serial clock line |
| sdaIn | input | 1 | Sampled level of the serial data line |
| sdaOut | output | 1 | Data line drive: 0 pulls low, 1 releases |

## Verification
A wrong mode, bit count or pending mode shows up on the output within one SCL pulse. The slave either pulls the line low outside an acknowledge pulse or leaves it released on the ninth pulse, and the bench sees this on the next SCL high phase. A pointer or stored-byte fault cannot be seen while it happens. It appears only when a later read returns the wrong bit in the high phase where that bit is due. For that reason every write in the bench is followed by reads that cover the same addresses, including the wrap past 0xFF.

// File: rtl/eepromPkg.sv
package eepromPkg;

  typedef enum logic [2:0] {
    MODE_IDLE,
    MODE_DEV,
    MODE_WADDR,
    MODE_READ,
    MODE_WRITE,
    MODE_ACKOUT,
    MODE_ACKIN
  } busMode_t;

  typedef struct packed {
    logic shiftIn;
    logic emitBit;
    logic driveLow;
    logic relBus;
    logic loadRead;
    logic loadPtr;
    logic storeByte;
    logic incPtr;
  } dpStrobe_t;

endpackage

// File: rtl/eeCtrl.sv
module eeCtrl
  import eepromPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [3:0] DEV_PATTERN = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] shByte,
  output dpStrobe_t         st,
  output logic              sdaSample
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic sclQ, sdaQ, sclP, sdaP;
  busMode_t mode, modeD, pend, pendD;
  logic [CNT_W-1:0] cnt, cntD;
  logic startDet, stopDet, riseE, fallE, cntFull, devMatch, rwBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      sclP <= sclQ;
      sdaP <= sdaQ;
    end
  end

  assign sdaSample = sdaQ;
  assign startDet  = sclP & sclQ & sdaP & ~sdaQ;
  assign stopDet   = sclP & sclQ & ~sdaP & sdaQ;
  assign riseE     = ~sclP & sclQ;
  assign fallE     = sclP & ~sclQ;
  assign cntFull   = (cnt == CNT_W'(BYTE_W));
  assign devMatch  = (shByte[BYTE_W-1 -: 4] == DEV_PATTERN);
  assign rwBit     = shByte[0];

  always_comb begin
    modeD = mode;
    pendD = pend;
    cntD  = cnt;
    st    = '0;
    if (startDet) begin
      modeD     = MODE_DEV;
      cntD      = '0;
      st.relBus = 1'b1;
    end else if (stopDet) begin
      modeD     = MODE_IDLE;
      st.relBus = 1'b1;
    end else if (riseE) begin
      case (mode)
        MODE_DEV, MODE_WADDR, MODE_WRITE: begin
          if (!cntFull) begin
            st.shiftIn = 1'b1;
            cntD       = cnt + CNT_W'(1);
          end
        end
        MODE_READ: begin
          if (!cntFull) begin
            st.emitBit = 1'b1;
            cntD       = cnt + CNT_W'(1);
          end
        end
        MODE_ACKOUT: st.driveLow = 1'b1;
        MODE_ACKIN: begin
          if (!sdaQ) begin
            pendD       = MODE_READ;
            st.loadRead = 1'b1;
          end else begin
            pendD = MODE_IDLE;
          end
        end
        default: ;
      endcase
    end else if (fallE) begin
      case (mode)
        MODE_DEV: begin
          if (cntFull) begin
            cntD      = '0;
            st.relBus = 1'b1;
            if (devMatch) begin
              modeD       = MODE_ACKOUT;
              pendD       = rwBit ? MODE_READ : MODE_WADDR;
              st.loadRead = rwBit;
            end else begin
              modeD = MODE_IDLE;
            end
          end
        end
        MODE_WADDR: begin
          if (cntFull) begin
            cntD       = '0;
            modeD      = MODE_ACKOUT;
            pendD      = MODE_WRITE;
            st.loadPtr = 1'b1;
            st.relBus  = 1'b1;
          end
        end
        MODE_READ: begin
          if (cntFull) begin
            modeD     = MODE_ACKIN;
            st.incPtr = 1'b1;
            st.relBus = 1'b1;
          end
        end
        MODE_WRITE: begin
          if (cntFull) begin
            cntD         = '0;
            modeD        = MODE_ACKOUT;
            pendD        = MODE_WRITE;
            st.storeByte = 1'b1;
            st.incPtr    = 1'b1;
            st.relBus    = 1'b1;
          end
        end
        MODE_ACKOUT, MODE_ACKIN: begin
          modeD     = pend;
          cntD      = '0;
          st.relBus = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= MODE_IDLE;
      pend <= MODE_IDLE;
      cnt  <= '0;
    end else begin
      mode <= modeD;
      pend <= pendD;
      cnt  <= cntD;
    end
  end

  // R2: START always opens a device byte
  p_start_dev_r2: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (mode == MODE_DEV && cnt == '0));

  // R2: STOP always ends in idle
  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (mode == MODE_IDLE));

  // R3: a rejected device byte parks the slave
  p_reject_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_DEV && fallE && cntFull && !devMatch) |=> (mode == MODE_IDLE));

  // R3: bit counter never passes one byte
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(BYTE_W));

endmodule

// File: rtl/eeData.sv
module eeData
  import eepromPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic              sdaSample,
  output logic [BYTE_W-1:0] shByte,
  output logic              sdaOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] rdReg;
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shByte <= '0;
      rdReg  <= '0;
      ptr    <= '0;
      sdaOut <= 1'b1;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (st.shiftIn) shByte <= {shByte[BYTE_W-2:0], sdaSample};
      if (st.loadRead) begin
        rdReg <= mem[ptr];
      end else if (st.emitBit) begin
        rdReg  <= {rdReg[BYTE_W-2:0], 1'b0};
        sdaOut <= rdReg[BYTE_W-1];
      end
      if (st.driveLow) sdaOut <= 1'b0;
      if (st.relBus) sdaOut <= 1'b1;
      if (st.storeByte) mem[ptr] <= shByte;
      if (st.loadPtr) ptr <= shByte[ADDR_W-1:0];
      else if (st.incPtr) ptr <= ptr + ADDR_W'(1);
    end
  end

  // R4: acknowledge strobe pulls the line low
  p_ack_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.driveLow |=> !sdaOut);

  // R7: release strobe frees the line
  p_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.relBus |=> sdaOut);

  // R6: a stored byte advances the pointer by one
  p_store_advance_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.storeByte |=> (ptr == $past(ptr) + ADDR_W'(1)));

  // R5: word address lands in the pointer
  p_ptr_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.loadPtr |=> (ptr == $past(shByte[ADDR_W-1:0])));

  // R4: drive-low and release never requested together
  p_drive_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.driveLow, st.relBus}));

endmodule

// File: rtl/eepromSlave.sv
module eepromSlave
  import eepromPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [3:0] DEV_PATTERN = 4'b1010
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOut
);

  dpStrobe_t         st;
  logic [BYTE_W-1:0] shByte;
  logic              sdaSample;

  eeCtrl #(.BYTE_W(BYTE_W), .DEV_PATTERN(DEV_PATTERN)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .shByte(shByte), .st(st), .sdaSample(sdaSample)
  );

  eeData #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) i_data (
    .clk(clk), .rstN(rstN), .st(st), .sdaSample(sdaSample),
    .shByte(shByte), .sdaOut(sdaOut)
  );

endmodule

// File: tb/test_eepromSlave.sv
`timescale 1ns/1ps
module test_eepromSlave;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic sdaOut;

  int tests = 0;
  int fails = 0;
  int expMem [256];
  int expPtr = 0;

  always #2 clk = ~clk;

  eepromSlave i_eepromSlave (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda), .sdaOut(sdaOut)
  );

  task automatic check(input logic expV, input string req);
    tests++;
    if (sdaOut !== expV) begin
      fails++;
      $display("FAIL %s: sdaOut got %b expected %b", req, sdaOut, expV);
    end
  endtask

  task automatic step(input logic s, input logic d);
    @(negedge clk);
    scl = s;
    sda = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic busStart();
    step(scl, 1'b1);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic busStop();
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
  endtask

  task automatic sendBit(input logic b);
    step(1'b0, b);
    step(1'b1, b);
    step(1'b0, b);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string req);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    check(expAck ? 1'b0 : 1'b1, {req, " ack pulse"});
    step(1'b0, 1'b1);
    check(1'b1, {req, " release after ack"});
  endtask

  task automatic readByte(input logic [7:0] expB, input logic ack);
    step(1'b0, 1'b1);
    for (int i = 7; i >= 0; i--) begin
      step(1'b1, 1'b1);
      check(expB[i], $sformatf("R7 read bit %0d of 0x%02h", i, expB));
      step(1'b0, 1'b1);
    end
    step(1'b0, ack ? 1'b0 : 1'b1);
    step(1'b1, ack ? 1'b0 : 1'b1);
    check(1'b1, "R7 released in master ack");
    step(1'b0, ack ? 1'b0 : 1'b1);
  endtask

  task automatic wrSeq(input logic [7:0] dev, input logic [7:0] addr, input int bytes[$]);
    busStart();
    sendByte(dev, 1'b1, "R3 device write");
    sendByte(addr, 1'b1, "R5 word address");
    expPtr = addr;
    foreach (bytes[k]) begin
      sendByte(8'(bytes[k]), 1'b1, "R6 data byte");
      expMem[expPtr] = bytes[k];
      expPtr = (expPtr + 1) % 256;
    end
    busStop();
  endtask

  task automatic rdSeq(input logic [7:0] dev, input int n);
    busStart();
    sendByte(dev, 1'b1, "R3 device read");
    for (int k = 0; k < n; k++) begin
      readByte(8'(expMem[expPtr]), (k < n - 1));
      expPtr = (expPtr + 1) % 256;
    end
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) expMem[i] = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(1'b1, "R1 output released after reset");

    // R1: pointer 0 and zero contents after reset
    rdSeq(8'hA1, 2);

    // R5 R6: multi-byte write, then read back with R8 acks
    wrSeq(8'hA0, 8'h10, '{8'hA5, 8'h3C, 8'hFF});
    wrSeq(8'hA0, 8'h10, '{});
    rdSeq(8'hA1, 3);

    // R6: wrap past 0xFF, device bits 3:1 don't care (R3)
    wrSeq(8'hAE, 8'hFE, '{8'h11, 8'h22, 8'h33});
    wrSeq(8'hA0, 8'hFE, '{});
    rdSeq(8'hAF, 4);

    // R3: mismatched device bytes ignored
    busStart();
    sendByte(8'hB0, 1'b0, "R3 mismatch B0");
    sendByte(8'h77, 1'b0, "R3 ignored byte");
    sendByte(8'hEE, 1'b0, "R3 ignored byte");
    busStop();
    busStart();
    sendByte(8'h20, 1'b0, "R3 mismatch 20");
    sendByte(8'h05, 1'b0, "R3 ignored byte");
    busStop();
    rdSeq(8'hA1, 1);

    // R2: STOP in the middle of a data byte stores nothing
    wrSeq(8'hA0, 8'h40, '{8'h99});
    busStart();
    sendByte(8'hA0, 1'b1, "R2 device");
    sendByte(8'h40, 1'b1, "R2 address");
    expPtr = 8'h40;
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStop();
    rdSeq(8'hA1, 1);

    // R2: repeated START turns an address set into a read
    busStart();
    sendByte(8'hA0, 1'b1, "R2 device");
    sendByte(8'h10, 1'b1, "R2 address");
    expPtr = 8'h10;
    busStart();
    sendByte(8'hA1, 1'b1, "R2 restart read");
    readByte(8'(expMem[expPtr]), 1'b0);
    expPtr = (expPtr + 1) % 256;

    // R8: after NACK the slave stays idle, no ack on further clocks
    sendByte(8'hA0, 1'b0, "R8 idle after nack");
    sendByte(8'h00, 1'b0, "R8 idle after nack");
    busStop();
    rdSeq(8'hA1, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule